// File: doc/BRIEF.md
# Multi-Phase Serial Audio Transmitter

The block turns parallel audio words into a serial bit stream. A host writes one word at a time into a holding register. Each frame-sync pulse starts a frame. The block then copies words from the holding register into a shift register and sends them most significant bit first on `sd_o`. A sample rate generator outside the block paces the stream with a one-cycle bit-clock enable on `bclk_en_i`. Frame sync, the release bit and all serial output changes are acted on only in cycles where this enable is high.

A frame holds one or two phases. Each phase has its own word count and its own word length. The first data bit leaves either on the same bit-clock tick as the frame sync or one tick later. The block raises `req_o` when the holding register has been consumed. If the host misses a word, the holding register still holds the old word, so that word is sent again. A frame-sync pulse that arrives while a frame is still running never disturbs the frame. It raises a sticky error flag unless the control word tells the block to ignore such pulses.

Top module: `serial_audio_tx`

## Requirements
- R1: The 3-bit word-length code selects the bits sent per word: 0 gives 8, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24, and 5, 6 and 7 give 32. Only the low word-length bits of the written word are sent, most significant first, one bit per tick.
- R2: `ctrl_i` is decoded as follows: phase-1 code at bits 7:5, phase-1 word count minus one at bits 14:8, data delay at bits 17:16 (zero means no delay, any other value means one tick), ignore-early-sync at bit 18, phase-2 code at bits 23:21, phase-2 word count minus one at bits 30:24, dual-phase enable at bit 31.
- R3: With delay zero, the first data bit appears on the tick that samples the frame sync. With delay one, `sd_o` is 0 on that tick and the first bit follows on the next tick.
- R4: A single-phase frame sends phase-1-count words back to back, with no gap ticks between words.
- R5: With dual-phase enabled, the phase-2 words follow the last phase-1 word on the next tick, each at the phase-2 word length, all from a single frame sync.
- R6: A frame sync sampled during the delay tick or before the final tick of a frame sets `sync_err_o`, unless bit 18 is set. In both cases the running frame's output is unchanged.
- R7: `xmit_en_i` is sampled only on ticks. Until a tick has seen it high, frame syncs start nothing and `sd_o` stays 0. A tick that sees it low clears `sync_err_o`, which otherwise holds.
- R8: When no new word has been written before a word slot starts (underrun), the last written word is sent again.
- R9: `req_o` is 0 after reset. It rises in the cycle after the holding register is copied into the shift register, and it falls in the cycle after a write. A write wins over a copy in the same cycle.
- R10: `sd_o` changes only in the cycle after a tick, and it is 0 on ticks outside a frame.
- R11: A frame sync on the first tick after a frame's last bit starts a new frame without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_en_i | input | 1 | Bit-clock enable tick from the sample rate generator |
| fsync_i | input | 1 | Frame-sync pulse, sampled on ticks |
| xmit_en_i | input | 1 | Transmitter release; low holds the transmitter in reset |
| ctrl_i | input | 32 | Frame format control word |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 32 | Word to be sent |
| sd_o | output | 1 | Serial data |
| req_o | output | 1 | Holding register consumed; ready for a new word |
| sync_err_o | output | 1 | Sticky early frame-sync error |

## Verification
The assertions check on every cycle that `sd_o` is quiet between ticks and that a write drops `req_o`. They also check that the error flag rises only on a tick and, once set, holds until a tick sees the release low. The remaining assertions check that the bit counter stays within the current word length and that the controller never issues two shifter actions at once. Only the bench's scenarios can show the actual bit streams. These are checked against streams computed arithmetically for a sweep of word-length codes, word counts, delays and dual-phase pairs. The bench scenarios also cover the repeated words on underrun, the start behaviour of the release, and back-to-back frames.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned FLEN_W = 7;
  localparam int unsigned BITS_W = 6;

  typedef struct packed {
    logic              dual;
    logic [FLEN_W-1:0] flen2;
    logic [CODE_W-1:0] code2;
    logic              ignore;
    logic [1:0]        delay;
    logic [FLEN_W-1:0] flen1;
    logic [CODE_W-1:0] code1;
  } tx_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_DLY, ST_SEND} tx_state_e;

  function automatic logic [BITS_W-1:0] wlen_bits(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    return 6'd8;
      3'd1:    return 6'd12;
      3'd2:    return 6'd16;
      3'd3:    return 6'd20;
      3'd4:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/serial_tx_cfg_dec.sv
module serial_tx_cfg_dec
  import serial_tx_pkg::*;
(
  input  logic [31:0] ctrl_i,
  output tx_cfg_t     cfg_o
);
  localparam int CODE1_LSB = 5;
  localparam int FLEN1_LSB = 8;
  localparam int DLY_LSB   = 16;
  localparam int IGN_BIT   = 18;
  localparam int CODE2_LSB = 21;
  localparam int FLEN2_LSB = 24;
  localparam int DUAL_BIT  = 31;

  always_comb begin
    cfg_o.code1  = ctrl_i[CODE1_LSB +: CODE_W];
    cfg_o.flen1  = ctrl_i[FLEN1_LSB +: FLEN_W];
    cfg_o.delay  = ctrl_i[DLY_LSB +: 2];
    cfg_o.ignore = ctrl_i[IGN_BIT];
    cfg_o.code2  = ctrl_i[CODE2_LSB +: CODE_W];
    cfg_o.flen2  = ctrl_i[FLEN2_LSB +: FLEN_W];
    cfg_o.dual   = ctrl_i[DUAL_BIT];
  end
endmodule

// File: rtl/serial_tx_dreg.sv
module serial_tx_dreg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              copy_i,
  output logic [DATA_W-1:0] data_o,
  output logic              req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      req_o  <= 1'b0;
    end else begin
      if (wr_i) data_o <= wr_data_i;
      if (wr_i)        req_o <= 1'b0;
      else if (copy_i) req_o <= 1'b1;
    end
  end

  AST_REQ_ON_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_i && !wr_i |=> req_o); // R9
endmodule

// File: rtl/serial_tx_shifter.sv
module serial_tx_shifter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BITS_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              clear_i,
  input  logic [BITS_W-1:0] wbits_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sd_o
);
  localparam int unsigned SH_W = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] aligned;
  logic [SH_W-1:0]   sh_amt;

  // put the top bit of the active word at the MSB
  always_comb begin
    sh_amt  = SH_W'(DATA_W) - SH_W'(wbits_i);
    aligned = data_i << sh_amt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      sd_o <= 1'b0;
    end else if (load_i) begin
      sd_o <= aligned[DATA_W-1];
      sh_q <= aligned << 1;
    end else if (shift_i) begin
      sd_o <= sh_q[DATA_W-1];
      sh_q <= sh_q << 1;
    end else if (clear_i) begin
      sd_o <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_tx_frame_ctl.sv
module serial_tx_frame_ctl
  import serial_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              fsync_i,
  input  logic              xmit_en_i,
  input  tx_cfg_t           cfg_i,
  output logic              load_o,
  output logic              shift_o,
  output logic              clear_o,
  output logic [BITS_W-1:0] wbits_o,
  output logic              sync_err_o
);
  tx_state_e         state_q, state_n;
  logic              en_q;
  logic              ph2_q, ph2_n;
  logic [FLEN_W-1:0] word_q, word_n;
  logic [BITS_W-1:0] bits_q, bits_n;
  logic [BITS_W-1:0] wl_p1, wl_p2, wl_cur;
  logic [FLEN_W-1:0] flen_cur;
  logic word_done, last_in_phase, frame_end, free, early;

  always_comb begin
    wl_p1         = wlen_bits(cfg_i.code1);
    wl_p2         = wlen_bits(cfg_i.code2);
    wl_cur        = ph2_q ? wl_p2 : wl_p1;
    flen_cur      = ph2_q ? cfg_i.flen2 : cfg_i.flen1;
    word_done     = (state_q == ST_SEND) && (bits_q == '0);
    last_in_phase = (word_q == flen_cur);
    frame_end     = word_done && last_in_phase && (ph2_q || !cfg_i.dual);
    free          = (state_q == ST_IDLE) || frame_end;
    early         = tick_i && en_q && fsync_i && !free;
  end

  always_comb begin
    state_n = state_q;
    ph2_n   = ph2_q;
    word_n  = word_q;
    bits_n  = bits_q;
    load_o  = 1'b0;
    shift_o = 1'b0;
    clear_o = 1'b0;
    wbits_o = wl_cur;
    if (tick_i) begin
      if (!en_q) begin
        state_n = ST_IDLE;
        clear_o = 1'b1;
      end else if ((state_q == ST_SEND) && !word_done) begin
        shift_o = 1'b1;
        bits_n  = bits_q - 1'b1;
      end else if (word_done && !frame_end) begin
        load_o = 1'b1;
        if (last_in_phase) begin
          ph2_n   = 1'b1;
          word_n  = '0;
          wbits_o = wl_p2;
          bits_n  = wl_p2 - 1'b1;
        end else begin
          word_n = word_q + 1'b1;
          bits_n = wl_cur - 1'b1;
        end
      end else if (state_q == ST_DLY) begin
        load_o  = 1'b1;
        wbits_o = wl_p1;
        bits_n  = wl_p1 - 1'b1;
        state_n = ST_SEND;
      end else if (fsync_i) begin
        ph2_n  = 1'b0;
        word_n = '0;
        if (cfg_i.delay == 2'd0) begin
          load_o  = 1'b1;
          wbits_o = wl_p1;
          bits_n  = wl_p1 - 1'b1;
          state_n = ST_SEND;
        end else begin
          clear_o = 1'b1;
          state_n = ST_DLY;
        end
      end else begin
        state_n = ST_IDLE;
        clear_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      en_q       <= 1'b0;
      ph2_q      <= 1'b0;
      word_q     <= '0;
      bits_q     <= '0;
      sync_err_o <= 1'b0;
    end else begin
      state_q <= state_n;
      ph2_q   <= ph2_n;
      word_q  <= word_n;
      bits_q  <= bits_n;
      if (tick_i) en_q <= xmit_en_i;
      if (tick_i && !xmit_en_i)        sync_err_o <= 1'b0;
      else if (early && !cfg_i.ignore) sync_err_o <= 1'b1;
    end
  end

  AST_ERR_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_err_o) |-> $past(tick_i)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_err_o && !(tick_i && !xmit_en_i) |=> sync_err_o); // R7
  AST_BITS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEND) |-> (bits_q < wl_cur)); // R1
  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_o, shift_o, clear_o})); // R10
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
  import serial_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_en_i,
  input  logic              fsync_i,
  input  logic              xmit_en_i,
  input  logic [31:0]       ctrl_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              sd_o,
  output logic              req_o,
  output logic              sync_err_o
);
  tx_cfg_t           cfg;
  logic              load, shift, clear;
  logic [BITS_W-1:0] wbits;
  logic [DATA_W-1:0] hold_data;

  serial_tx_cfg_dec u_dec (
    .ctrl_i (ctrl_i),
    .cfg_o  (cfg)
  );

  serial_tx_frame_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (bclk_en_i),
    .fsync_i    (fsync_i),
    .xmit_en_i  (xmit_en_i),
    .cfg_i      (cfg),
    .load_o     (load),
    .shift_o    (shift),
    .clear_o    (clear),
    .wbits_o    (wbits),
    .sync_err_o (sync_err_o)
  );

  serial_tx_dreg #(.DATA_W(DATA_W)) u_dreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .copy_i    (load),
    .data_o    (hold_data),
    .req_o     (req_o)
  );

  serial_tx_shifter #(.DATA_W(DATA_W), .BITS_W(BITS_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .clear_i (clear),
    .wbits_i (wbits),
    .data_i  (hold_data),
    .sd_o    (sd_o)
  );

  AST_SD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bclk_en_i |=> $stable(sd_o)); // R10
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !req_o); // R9
endmodule

// File: tb/serial_audio_tx_tb_top.sv
module serial_audio_tx_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk_en = 1'b0, fsync = 1'b0, xmit_en = 1'b0, wr = 1'b0;
  logic [31:0] ctrl = '0, wr_data = '0;
  logic        sd, req, serr;

  int checks = 0, errors = 0;
  logic [31:0] feed_data [0:7];
  int feed_n = 0, feed_idx = 0;
  bit exp_bits [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_audio_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bclk_en_i(bclk_en), .fsync_i(fsync),
    .xmit_en_i(xmit_en), .ctrl_i(ctrl), .wr_i(wr), .wr_data_i(wr_data),
    .sd_o(sd), .req_o(req), .sync_err_o(serr)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  function automatic int wl_of(input int code);
    case (code)
      0: return 8;  1: return 12; 2: return 16;
      3: return 20; 4: return 24; default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] mk(input int c1, input int f1, input int d,
                                     input int ign, input int c2, input int f2,
                                     input int dual);
    return {dual[0], f2[6:0], c2[2:0], 2'b00, ign[0], d[1:0], 1'b0,
            f1[6:0], c1[2:0], 5'b00000};
  endfunction

  // one bit-clock tick; sd sampled after the ticking edge, feeder writes after
  task automatic tick(input bit fs, output bit s);
    @(negedge clk); bclk_en = 1'b1; fsync = fs;
    @(negedge clk); bclk_en = 1'b0; fsync = 1'b0; s = sd;
    if (req && feed_idx < feed_n) begin
      wr = 1'b1; wr_data = feed_data[feed_idx]; feed_idx++;
      @(negedge clk); wr = 1'b0;
    end else @(negedge clk);
    @(negedge clk);
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 8; i++) feed_data[i] = 32'h9E37_79B9 * (seed * 8 + i + 1) ^ 32'h5A5A_0F0F;
  endtask

  task automatic run_frame(input logic [31:0] c, input int n_wr, input int fs2_at,
                           input int trail, input string rq);
    int c1, c2, f1, f2, d, nb, k, bad, first_t;
    bit s, e, first_a, first_e;
    c1 = c[7:5]; f1 = c[14:8]; d = (c[17:16] != 0); c2 = c[23:21]; f2 = c[30:24];
    nb = 0; k = 0;
    for (int w = 0; w < f1 + 1; w++) begin
      logic [31:0] v = feed_data[k < n_wr ? k : n_wr - 1];
      for (int b = wl_of(c1) - 1; b >= 0; b--) begin exp_bits[nb] = v[b]; nb++; end
      k++;
    end
    if (c[31]) for (int w = 0; w < f2 + 1; w++) begin
      logic [31:0] v = feed_data[k < n_wr ? k : n_wr - 1];
      for (int b = wl_of(c2) - 1; b >= 0; b--) begin exp_bits[nb] = v[b]; nb++; end
      k++;
    end
    ctrl = c;
    @(negedge clk); wr = 1'b1; wr_data = feed_data[0];
    @(negedge clk); wr = 1'b0;
    feed_idx = 1; feed_n = n_wr;
    bad = 0; first_t = -1; first_a = 0; first_e = 0;
    for (int t = 0; t < d + nb + trail; t++) begin
      tick(t == 0 || t == fs2_at, s);
      e = (t < d) ? 1'b0 : (t < d + nb) ? exp_bits[t - d] : 1'b0;
      if (s != e) begin
        bad++;
        if (first_t < 0) begin first_t = t; first_a = s; first_e = e; end
      end
    end
    check(bad == 0, rq, $sformatf("stream ctrl=%08h first bad tick %0d", c, first_t),
          first_a, first_e);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    bit s;
    int seed;
    seed = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sd == 0 && req == 0 && serr == 0, "R9", "reset outputs", {sd, req, serr}, 0);

    // R7: held in reset, fsync starts nothing
    fill(seed++); ctrl = mk(2, 0, 0, 0, 0, 0, 0);
    @(negedge clk); wr = 1'b1; wr_data = 32'hFFFF_FFFF; @(negedge clk); wr = 1'b0;
    begin
      int ones = 0;
      for (int t = 0; t < 6; t++) begin tick(t == 0, s); ones += s; end
      check(ones == 0 && req == 0, "R7", "disabled stream", ones, 0);
      xmit_en = 1'b1;
      ones = 0;
      for (int t = 0; t < 6; t++) begin tick(t == 0, s); ones += s; end
      check(ones == 0 && req == 0, "R7", "release takes a tick", ones, 0);
    end

    // R9: copy raises req, write drops it
    fill(seed++);
    feed_n = 0;
    @(negedge clk); wr = 1'b1; wr_data = feed_data[0]; @(negedge clk); wr = 1'b0;
    tick(1'b1, s);
    check(req == 1, "R9", "req after copy", req, 1);
    @(negedge clk); wr = 1'b1; wr_data = feed_data[1]; @(negedge clk); wr = 1'b0;
    check(req == 0, "R9", "req after write", req, 0);
    for (int t = 0; t < 20; t++) tick(1'b0, s);

    // R1 R3 R4: single-phase sweep over code, delay and count
    for (int c1 = 0; c1 < 8; c1++)
      for (int d = 0; d < 2; d++)
        for (int f = 0; f < 3; f++) begin
          fill(seed++);
          run_frame(mk(c1, f, d == 0 ? 0 : (c1 % 2 ? 3 : 1), 0, 0, 0, 0), f + 1, -1, 2,
                    "R1 R3 R4");
        end

    // R2 R5: dual-phase sweep with separate lengths and counts
    for (int c1 = 0; c1 < 6; c1 += 2)
      for (int c2 = 0; c2 < 6; c2++)
        for (int f = 0; f < 4; f++) begin
          fill(seed++);
          run_frame(mk(c1, f % 2, c2 % 2, 0, c2, f / 2, 1), f % 2 + f / 2 + 2, -1, 2,
                    "R2 R5");
        end
    check(serr == 0, "R6", "no error after clean frames", serr, 0);

    // R8: underrun repeats the last written word
    fill(seed++); run_frame(mk(1, 2, 0, 0, 0, 0, 0), 1, -1, 2, "R8 single word");
    fill(seed++); run_frame(mk(0, 1, 1, 0, 3, 1, 1), 2, -1, 2, "R8 dual");

    // R11: back-to-back frames
    fill(seed++); run_frame(mk(0, 0, 0, 0, 0, 0, 0), 1, -1, 0, "R11 first");
    fill(seed++); run_frame(mk(0, 0, 0, 0, 0, 0, 0), 1, -1, 2, "R11 second");
    check(serr == 0, "R11", "no error back to back", serr, 0);

    // R6: early fsync with ignore set
    fill(seed++); run_frame(mk(2, 1, 0, 1, 0, 0, 0), 2, 5, 2, "R6 ignored stream");
    check(serr == 0, "R6", "ignore bit suppresses error", serr, 1'b0);
    // R6: early fsync in the delay tick
    fill(seed++); run_frame(mk(0, 0, 1, 0, 0, 0, 0), 1, 1, 2, "R6 delay-tick stream");
    check(serr == 1, "R6", "error from delay tick", serr, 1);
    // R7: error holds without a tick, clears on a tick with release low
    xmit_en = 1'b0;
    repeat (3) @(negedge clk);
    check(serr == 1, "R7", "error held without tick", serr, 1);
    tick(1'b0, s);
    check(serr == 0, "R7", "error cleared on tick", serr, 0);
    xmit_en = 1'b1; tick(1'b0, s);
    // R6: early fsync mid-frame, frame unchanged
    fill(seed++); run_frame(mk(2, 1, 1, 0, 0, 0, 0), 2, 9, 2, "R6 mid-frame stream");
    check(serr == 1, "R6", "error mid-frame", serr, 1);

    summary();
    $finish;
  end
endmodule